// File: doc/BRIEF.md
# Adapter Host-Interface Glue Registers

This block is the byte-wide I/O window that a host bus sees on a network adapter. Half of the window holds a few glue control registers. The other half is a data window. That data window shows either the ring controller's own register file or a small identification ROM. The ROM has two pages: identity bytes on one and the station address on the other. It reads back at the same offsets the controller registers would use.

The control registers have several jobs. They choose what the data window shows and pick the ROM page. They supply the top register-select bit that the controller cannot get from the window's address lines. They hold the controller in reset, and they drive the ring-speed and cable-type outputs. They also gate an interrupt latch toward a level-triggered host line. A rising edge on the controller's interrupt request sets the latch. The latch stays set until the host turns the enable bit off and back on, or until reset.

Host address bit 3 picks the half. When it is clear, offsets 0, 1 and 7 are the registers called ctl0, ctl1 and cable. When it is set, address bits 2..0 form the data-window offset.

Top module: `hif_glue`

## Requirements
- R1: After synchronous reset every control bit is zero. So ctl_run_n is 0, host_irq is 0, speed_16 is 0, cable_utp is 0, and the window shows ROM page zero.
- R2: ctl0 (offset 0), ctl1 (offset 1) and cable (offset 7) read back the last value written to them, except ctl0 bit 1. Other control offsets read 0 and ignore writes.
- R3: With ctl0 bit 3 clear, the ROM window returns the following bytes: offset 0 is 0x4D, offset 1 is the card type and offset 2 is the revision. Offsets 3..5 return cfg_mirror bytes 0..2, with byte 0 in bits 7:0. Offsets 6 and 7 return 0.
- R4: With ctl0 bit 3 set, the ROM window returns 0 at offsets 0 and 7. Offsets 1..6 return the six station-address bytes, most significant byte first.
- R5: While ctl0 bit 2 is set, a window access pulses ctl_rd or ctl_wr and a window read returns ctl_rdata. While it is clear, there are no controller strobes, window reads come from the ROM, and window writes have no effect.
- R6: ctl_sel equals {ctl1 bit 2, address bits 2:1}. ctl_byte equals address bit 0, and ctl_wdata equals bus_wdata.
- R7: ctl_run_n follows ctl1 bit 0. Writing 0 to ctl1 holds the controller in reset.
- R8: A rising edge on ctl_irq_req sets the interrupt latch on the next clock. The latch shows as ctl0 bit 1 and stays set after the request falls.
- R9: host_irq is high exactly when the latch is set and ctl1 bit 1 is set. The latch still sets while that bit is clear.
- R10: A write that clears ctl1 bit 1 while the bit is set also clears the latch. A rising request edge in the same cycle wins.
- R11: speed_16 follows ctl1 bit 3, with 1 meaning 16 Mb/s and 0 meaning 4 Mb/s.
- R12: cable_utp follows bit 0 of the cable register, with 1 meaning UTP and 0 meaning STP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Host byte address within the window |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| cfg_mirror | input | 24 | Bus configuration bytes mirrored into ROM page zero |
| ctl_sel | output | 3 | Controller register select |
| ctl_byte | output | 1 | Controller byte lane |
| ctl_wr | output | 1 | Controller write strobe |
| ctl_rd | output | 1 | Controller read strobe |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rdata | input | 8 | Controller read data |
| ctl_irq_req | input | 1 | Controller interrupt request |
| ctl_run_n | output | 1 | Controller reset, low holds it in reset |
| host_irq | output | 1 | Level interrupt toward the host |
| speed_16 | output | 1 | Ring speed select |
| cable_utp | output | 1 | Cable type select |

## Verification
Directed patterns come first, and each one separates a particular mistake. ROM sweeps on both pages catch page-select or byte-order errors. Window accesses with the controller mapped, and then unmapped, show whether strobes leak while the ROM is in view. Repeating the mapped accesses with the top select bit toggled exposes a wrong select composition.

Interrupt sequences raise the request with the enable off, then on, drop the request, and toggle the enable. One sequence makes a clear and a new edge coincide, which tells a sticky, edge-set latch apart from a level follower and shows the set-over-clear priority. A long pseudo-random stream of reads, writes and request changes is then compared every cycle against the behavioural model.

// File: rtl/hif_pkg.sv
package hif_pkg;

    localparam int DATA_W     = 8;
    localparam int WIN_OFF_W  = 3;
    localparam int ROM_DEPTH  = 1 << WIN_OFF_W;
    localparam int CFG_BYTES  = 3;
    localparam int STA_BYTES  = 6;

    typedef enum logic [WIN_OFF_W-1:0] {
        REG_CTL0  = 3'd0,
        REG_CTL1  = 3'd1,
        REG_CABLE = 3'd7
    } ctl_idx_e;

    // window and page control
    typedef struct packed {
        logic [3:0] spare_hi;
        logic       rom_page;   // bit 3
        logic       sif_sel;    // bit 2
        logic       irq_stat;   // bit 1, read-only latch view
        logic       spare_lo;   // bit 0
    } ctl0_t;

    // controller control
    typedef struct packed {
        logic [3:0] spare_hi;
        logic       speed16;    // bit 3
        logic       srsx;       // bit 2
        logic       irq_en;     // bit 1
        logic       run_n;      // bit 0
    } ctl1_t;

    function automatic logic is_clear_edge(ctl1_t cur, logic [DATA_W-1:0] wdata);
        return cur.irq_en && !wdata[1];
    endfunction

endpackage

// File: rtl/hif_ctrl_regs.sv
module hif_ctrl_regs
    import hif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WIN_OFF_W-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              latch,
    output ctl0_t             ctl0,
    output ctl1_t             ctl1,
    output logic [DATA_W-1:0] cable,
    output logic [DATA_W-1:0] rd_byte,
    output logic              irq_clr
);

    ctl0_t             ctl0_q;
    ctl1_t             ctl1_q;
    logic [DATA_W-1:0] cable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl0_q  <= '0;
            ctl1_q  <= '0;
            cable_q <= '0;
        end else if (wr_en) begin
            case (ctl_idx_e'(idx))
                REG_CTL0:  ctl0_q  <= ctl0_t'(wdata & 8'hFD);
                REG_CTL1:  ctl1_q  <= ctl1_t'(wdata);
                REG_CABLE: cable_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_byte = '0;
        case (ctl_idx_e'(idx))
            REG_CTL0:  rd_byte = ctl0_q | {6'b0, latch, 1'b0};
            REG_CTL1:  rd_byte = ctl1_q;
            REG_CABLE: rd_byte = cable_q;
            default:   rd_byte = '0;
        endcase
    end

    assign irq_clr = wr_en && (ctl_idx_e'(idx) == REG_CTL1) && is_clear_edge(ctl1_q, wdata);
    assign ctl0  = ctl0_q;
    assign ctl1  = ctl1_q;
    assign cable = cable_q;

    // R1: one cycle out of reset every control bit is still zero
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctl0_q == '0 && ctl1_q == '0 && cable_q == '0));

endmodule

// File: rtl/hif_irq_latch.sv
module hif_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic clr,
    output logic latch
);

    logic req_q;
    logic rise;
    logic latch_q;

    assign rise = req && !req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            req_q <= req;
            if (rise)
                latch_q <= 1'b1;
            else if (clr)
                latch_q <= 1'b0;
        end
    end

    assign latch = latch_q;

    p_latch_set_r8: assert property (@(posedge clk) disable iff (rst)
        rise |=> latch_q);

    p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !clr) |=> latch_q);

    p_latch_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && !rise) |=> !latch_q);

endmodule

// File: rtl/hif_id_rom.sv
module hif_id_rom
    import hif_pkg::*;
#(
    parameter logic [DATA_W-1:0]                MFG_ID       = 8'h4D,
    parameter logic [DATA_W-1:0]                CARD_TYPE    = 8'h08,
    parameter logic [DATA_W-1:0]                CARD_REV     = 8'h02,
    parameter logic [STA_BYTES-1:0][DATA_W-1:0] STATION_ADDR = 48'h4000_1A2B_3C4D
) (
    input  logic                        page,
    input  logic [WIN_OFF_W-1:0]        off,
    input  logic [CFG_BYTES*DATA_W-1:0] cfg_mirror,
    output logic [DATA_W-1:0]           rom_byte
);

    localparam int CFG_BASE = 3;
    localparam int STA_BASE = 1;

    logic [DATA_W-1:0] page0 [ROM_DEPTH];
    logic [DATA_W-1:0] page1 [ROM_DEPTH];

    for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_rom
        if (i == 0) begin : g_p0_id
            assign page0[i] = MFG_ID;
        end else if (i == 1) begin : g_p0_type
            assign page0[i] = CARD_TYPE;
        end else if (i == 2) begin : g_p0_rev
            assign page0[i] = CARD_REV;
        end else if (i >= CFG_BASE && i < CFG_BASE + CFG_BYTES) begin : g_p0_cfg
            assign page0[i] = cfg_mirror[(i-CFG_BASE)*DATA_W +: DATA_W];
        end else begin : g_p0_pad
            assign page0[i] = '0;
        end

        if (i >= STA_BASE && i < STA_BASE + STA_BYTES) begin : g_p1_sta
            assign page1[i] = STATION_ADDR[STA_BYTES-1-(i-STA_BASE)];
        end else begin : g_p1_pad
            assign page1[i] = '0;
        end
    end

    assign rom_byte = page ? page1[off] : page0[off];

endmodule

// File: rtl/hif_glue.sv
module hif_glue
    import hif_pkg::*;
#(
    parameter int                               ADDR_W       = WIN_OFF_W + 1,
    parameter logic [DATA_W-1:0]                MFG_ID       = 8'h4D,
    parameter logic [DATA_W-1:0]                CARD_TYPE    = 8'h08,
    parameter logic [DATA_W-1:0]                CARD_REV     = 8'h02,
    parameter logic [STA_BYTES-1:0][DATA_W-1:0] STATION_ADDR = 48'h4000_1A2B_3C4D
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [CFG_BYTES*DATA_W-1:0] cfg_mirror,
    output logic [WIN_OFF_W-1:0]        ctl_sel,
    output logic                        ctl_byte,
    output logic                        ctl_wr,
    output logic                        ctl_rd,
    output logic [DATA_W-1:0]           ctl_wdata,
    input  logic [DATA_W-1:0]           ctl_rdata,
    input  logic                        ctl_irq_req,
    output logic                        ctl_run_n,
    output logic                        host_irq,
    output logic                        speed_16,
    output logic                        cable_utp
);

    localparam int OFF_W = ADDR_W - 1;

    logic              in_win;
    logic [OFF_W-1:0]  off;
    ctl0_t             ctl0;
    ctl1_t             ctl1;
    logic [DATA_W-1:0] cable;
    logic [DATA_W-1:0] reg_byte;
    logic [DATA_W-1:0] rom_byte;
    logic              irq_clr;
    logic              latch;

    assign in_win = bus_addr[ADDR_W-1];
    assign off    = bus_addr[OFF_W-1:0];

    hif_ctrl_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr && !in_win),
        .idx     (off),
        .wdata   (bus_wdata),
        .latch   (latch),
        .ctl0    (ctl0),
        .ctl1    (ctl1),
        .cable   (cable),
        .rd_byte (reg_byte),
        .irq_clr (irq_clr)
    );

    hif_irq_latch i_irq (
        .clk   (clk),
        .rst   (rst),
        .req   (ctl_irq_req),
        .clr   (irq_clr),
        .latch (latch)
    );

    hif_id_rom #(
        .MFG_ID       (MFG_ID),
        .CARD_TYPE    (CARD_TYPE),
        .CARD_REV     (CARD_REV),
        .STATION_ADDR (STATION_ADDR)
    ) i_rom (
        .page       (ctl0.rom_page),
        .off        (off),
        .cfg_mirror (cfg_mirror),
        .rom_byte   (rom_byte)
    );

    // controller side: top select bit from ctl1, lower bits from the word address
    assign ctl_sel   = {ctl1.srsx, off[OFF_W-1:1]};
    assign ctl_byte  = off[0];
    assign ctl_wdata = bus_wdata;
    assign ctl_wr    = bus_wr && in_win && ctl0.sif_sel;
    assign ctl_rd    = bus_rd && in_win && ctl0.sif_sel;

    always_comb begin
        if (!in_win)
            bus_rdata = reg_byte;
        else if (ctl0.sif_sel)
            bus_rdata = ctl_rdata;
        else
            bus_rdata = rom_byte;
    end

    assign ctl_run_n = ctl1.run_n;
    assign speed_16  = ctl1.speed16;
    assign cable_utp = cable[0];
    assign host_irq  = latch && ctl1.irq_en;

    // R5: no controller strobe while the ROM is mapped
    p_rom_lockout_r5: assert property (@(posedge clk) disable iff (rst)
        !ctl0.sif_sel |-> (!ctl_rd && !ctl_wr));

    // R9: the host line never rises without the enable
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !ctl1.irq_en |-> !host_irq);

endmodule

// File: tb/test_hif_glue.sv
module test_hif_glue;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [23:0] cfg_mirror = 24'hC3_B2_A1;
    logic [2:0] ctl_sel;
    logic       ctl_byte;
    logic       ctl_wr;
    logic       ctl_rd;
    logic [7:0] ctl_wdata;
    logic [7:0] ctl_rdata;
    logic       ctl_irq_req = 1'b0;
    logic       ctl_run_n;
    logic       host_irq;
    logic       speed_16;
    logic       cable_utp;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    // stand-in controller: read data encodes the select it sees
    assign ctl_rdata = {ctl_sel, ctl_byte, 4'hA};

    hif_glue i_hif_glue (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_mirror(cfg_mirror),
        .ctl_sel(ctl_sel), .ctl_byte(ctl_byte), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_irq_req(ctl_irq_req),
        .ctl_run_n(ctl_run_n), .host_irq(host_irq), .speed_16(speed_16),
        .cable_utp(cable_utp)
    );

    // behavioural reference state
    logic [7:0] m_c0, m_c1, m_c7;
    bit         m_latch, m_req_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_c0 <= 0; m_c1 <= 0; m_c7 <= 0; m_latch <= 0; m_req_prev <= 0;
        end else begin
            if (bus_wr && bus_addr < 8) begin
                if (bus_addr == 0) m_c0 <= bus_wdata & 8'hFD;
                if (bus_addr == 1) m_c1 <= bus_wdata;
                if (bus_addr == 7) m_c7 <= bus_wdata;
            end
            if (ctl_irq_req && !m_req_prev)
                m_latch <= 1;
            else if (bus_wr && bus_addr == 1 && m_c1[1] && !bus_wdata[1])
                m_latch <= 0;
            m_req_prev <= ctl_irq_req;
        end
    end

    function automatic logic [7:0] exp_rom(bit page, int off);
        logic [47:0] sta = 48'h4000_1A2B_3C4D;
        if (!page) begin
            case (off)
                0: return 8'h4D;
                1: return 8'h08;
                2: return 8'h02;
                3, 4, 5: return cfg_mirror[(off-3)*8 +: 8];
                default: return 8'h00;
            endcase
        end
        if (off >= 1 && off <= 6) return sta[(6-off)*8 +: 8];
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_rdata();
        int a = bus_addr;
        if (a < 8) begin
            if (a == 0) return m_c0 | (m_latch ? 8'h02 : 8'h00);
            if (a == 1) return m_c1;
            if (a == 7) return m_c7;
            return 8'h00;
        end
        if (m_c0[2]) return {m_c1[2], bus_addr[2:1], bus_addr[0], 4'hA};
        return exp_rom(m_c0[3], a - 8);
    endfunction

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string rtag);
        chk(rtag, "bus_rdata", bus_rdata, exp_rdata());
        chk("R6", "ctl_sel", {5'b0, ctl_sel}, {5'b0, m_c1[2], bus_addr[2:1]});
        chk("R6", "ctl_byte", {7'b0, ctl_byte}, {7'b0, bus_addr[0]});
        chk("R6", "ctl_wdata", ctl_wdata, bus_wdata);
        chk("R5", "ctl_wr", {7'b0, ctl_wr}, {7'b0, bus_wr && bus_addr[3] && m_c0[2]});
        chk("R5", "ctl_rd", {7'b0, ctl_rd}, {7'b0, bus_rd && bus_addr[3] && m_c0[2]});
        chk("R7", "ctl_run_n", {7'b0, ctl_run_n}, {7'b0, m_c1[0]});
        chk("R9", "host_irq", {7'b0, host_irq}, {7'b0, m_latch && m_c1[1]});
        chk("R11", "speed_16", {7'b0, speed_16}, {7'b0, m_c1[3]});
        chk("R12", "cable_utp", {7'b0, cable_utp}, {7'b0, m_c7[0]});
    endtask

    task automatic step(string rtag, int addr, bit wr, bit rd, logic [7:0] wd, bit req);
        @(negedge clk);
        bus_addr = addr[3:0]; bus_wr = wr; bus_rd = rd; bus_wdata = wd; ctl_irq_req = req;
        #1;
        compare_all(rtag);
    endtask

    task automatic wreg(string rtag, int addr, logic [7:0] wd, bit req);
        step(rtag, addr, 1, 0, wd, req);
    endtask

    task automatic rd(string rtag, int addr, bit req);
        step(rtag, addr, 0, 1, 8'h00, req);
    endtask

    initial begin
        // reset state, R1
        for (int i = 0; i < 3; i++) step("R1", 0, 0, 1, 8'h00, 0);
        chk("R1", "ctl_run_n", {7'b0, ctl_run_n}, 8'h00);
        chk("R1", "host_irq", {7'b0, host_irq}, 8'h00);
        @(negedge clk); rst = 1'b0;
        rd("R1", 8, 0);
        chk("R1", "rom byte0 after reset", bus_rdata, 8'h4D);

        // R3: page zero sweep
        for (int o = 0; o < 8; o++) rd("R3", 8 + o, 0);
        // R4: page one sweep
        wreg("R4", 0, 8'h08, 0);
        for (int o = 0; o < 8; o++) rd("R4", 8 + o, 0);
        rd("R4", 9, 0);
        chk("R4", "station msb", bus_rdata, 8'h40);

        // R2: readback of each register and an unused offset
        wreg("R2", 0, 8'hF1, 0); rd("R2", 0, 0);
        wreg("R2", 1, 8'hF8, 0); rd("R2", 1, 0);
        wreg("R2", 7, 8'hA3, 0); rd("R2", 7, 0);
        wreg("R2", 4, 8'h55, 0); rd("R2", 4, 0);
        wreg("R12", 7, 8'hA2, 0); rd("R12", 7, 0);
        wreg("R11", 1, 8'h00, 0); rd("R7", 1, 0);

        // R5/R6: mapped window, both values of the top select bit
        wreg("R5", 0, 8'h04, 0);
        wreg("R6", 1, 8'h01, 0);
        for (int o = 0; o < 8; o++) rd("R5", 8 + o, 0);
        step("R5", 13, 1, 0, 8'h3C, 0);
        wreg("R6", 1, 8'h05, 0);
        for (int o = 0; o < 8; o++) rd("R6", 8 + o, 0);
        // unmapped: writes ignored, ROM visible
        wreg("R5", 0, 8'h00, 0);
        step("R5", 10, 1, 0, 8'hEE, 0);
        rd("R5", 10, 0);
        chk("R5", "rom unchanged by write", bus_rdata, 8'h02);

        // R8/R9: latch sets with enable off, host line stays low
        wreg("R9", 1, 8'h01, 0);
        rd("R8", 0, 1);
        rd("R8", 0, 1);
        chk("R8", "status after rise", bus_rdata & 8'h02, 8'h02);
        chk("R9", "host_irq gated", {7'b0, host_irq}, 8'h00);
        rd("R8", 0, 0);
        chk("R8", "sticky after fall", bus_rdata & 8'h02, 8'h02);
        wreg("R9", 1, 8'h03, 0);
        rd("R9", 0, 0);
        chk("R9", "host_irq enabled", {7'b0, host_irq}, 8'h01);
        // R10: disable clears, re-enable keeps clear
        wreg("R10", 1, 8'h01, 0);
        wreg("R10", 1, 8'h03, 0);
        rd("R10", 0, 0);
        chk("R10", "latch cleared by toggle", bus_rdata & 8'h02, 8'h00);
        // R10: new edge coincides with clear, set wins
        rd("R10", 0, 0);
        wreg("R10", 1, 8'h01, 1);
        rd("R10", 0, 1);
        chk("R10", "set wins over clear", bus_rdata & 8'h02, 8'h02);

        // pseudo-random stream
        for (int n = 0; n < 400; n++) begin
            int r = $urandom;
            int a = r & 15;
            bit w = ((r >> 4) & 3) == 0;
            step("R2", a, w, (r >> 6) & 1, 8'((r >> 8) & 8'hFF), (r >> 16) & 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule